// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of a successive-approximation analog-to-digital converter. Software writes a start bit. On the next conversion-clock tick the block opens the sample-and-hold switch. It then resolves the result one bit per tick, starting at the most significant bit. For each bit it presents a trial code to the converter's DAC and reads back a single comparator decision. When every bit is resolved it does four things in one clock: it latches the code into a high/low result register pair, drops the busy/start bit, raises a sticky completion flag and closes the sample-and-hold switch again.

Software can clear the start bit while a conversion is running. The conversion is then abandoned and the previous result stays in place. The switch stays open for a fixed number of ticks before acquisition resumes. A start is honoured only while the converter was already enabled before the write. Dropping the enable returns the sequencer to idle at once. The analog path, channel selection and pin setup are outside this block.

Top module: `sar_seq_ctrl`

## Requirements
- R1: The tick that starts a conversion sets `trial_o` to only bit 9 (0x200). At each later decision tick for bit b, bit b stays set only if `cmp_i` is 1, and bit b-1 is then set.
- R2: The final code is loaded with bits 9:8 on `res_hi_o[1:0]` and bits 7:0 on `res_lo_o`. For a comparator that reports 1 when the input is at or above the trial code, the loaded code equals that input.
- R3: Completion happens on the 11th tick after the start tick. After the 10th tick `busy_o` still reads 1.
- R4: `hold_o` goes to 1 on the start tick. On the completion tick it returns to 0 in the same clock that `busy_o` clears and `irq_flag_o` sets.
- R5: Writing 0 to the start bit during a conversion clears `busy_o` at once and abandons the conversion. The result pair is not changed and `irq_flag_o` is not set.
- R6: After the tick that abandons a conversion, `hold_o` stays 1 for one further tick and falls on the second tick. A pending start begins no earlier than the tick after that.
- R7: A start write in the same clock in which `en_i` first goes high is ignored. A start is only accepted when `en_i` was already 1 in the previous clock.
- R8: Writing 1 to the start bit while a conversion is running changes neither its timing nor its result.
- R9: `irq_flag_o` stays set until a `flag_clr_i` pulse clears it. If a clear and a completion fall in the same clock, the flag ends up set.
- R10: Driving `en_i` low forces idle in the next clock: `busy_o`, `hold_o` and `trial_o` go to 0. The result pair and `irq_flag_o` are left unchanged.
- R11: The sequencer only advances on clocks where `tick_i` is 1. An accepted start with no tick leaves `hold_o` and `trial_o` at 0 however many clocks pass.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Conversion-clock enable, one system clock wide |
| en_i | input | 1 | Converter enable level |
| go_wr_i | input | 1 | Write strobe for the start/busy bit |
| go_wdata_i | input | 1 | Value written to the start/busy bit |
| flag_clr_i | input | 1 | Clears the completion flag |
| cmp_i | input | 1 | Comparator decision for the current trial code |
| busy_o | output | 1 | Start/busy bit as read by software |
| hold_o | output | 1 | 1 opens the sample-and-hold switch |
| trial_o | output | 10 | Trial code for the DAC |
| res_hi_o | output | 2 | Result bits 9:8 |
| res_lo_o | output | 8 | Result bits 7:0 |
| irq_flag_o | output | 1 | Sticky completion flag |

## Verification
The hardest case to reach from the ports is the restart that follows an abandoned conversion. It needs three things at once: a start write landing inside the two-tick wait, the switch still open, and an old result that must survive. The bench controls every tick by hand. It clears the start bit mid-conversion, issues a new start during the wait, and counts ticks one at a time to see exactly when the switch closes and when the new start opens it again. The comparator is modelled as an ideal compare of a chosen input code against `trial_o`, so each result is known in advance.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_ABORT = 2'd2
    } sar_state_e;
endpackage

// File: rtl/sar_bit_step.sv
// One successive-approximation decision on the trial code.
module sar_bit_step #(
    parameter int RES_W = 10,
    parameter int IDX_W = 4
) (
    input  logic [RES_W-1:0] trial_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_o
);
    always_comb begin
        trial_o = trial_i;
        for (int b = 0; b < RES_W; b++) begin
            if (IDX_W'(b) == idx_i && !cmp_i) begin
                trial_o[b] = 1'b0;
            end
            if (IDX_W'(b + 1) == idx_i) begin
                trial_o[b] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sar_result_reg.sv
// Result register pair, loaded only on completion.
module sar_result_reg #(
    parameter int RES_W = 10,
    parameter int LO_W  = 8,
    localparam int HI_W = RES_W - LO_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [RES_W-1:0] data_i,
    output logic [HI_W-1:0]  hi_o,
    output logic [LO_W-1:0]  lo_o
);
    logic [RES_W-1:0] res_d, res_q;

    always_comb begin
        res_d = load_i ? data_i : res_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_d;
    end

    assign hi_o = res_q[RES_W-1:LO_W];
    assign lo_o = res_q[LO_W-1:0];
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int LO_W       = 8,
    parameter int WAIT_TICKS = 2,
    localparam int HI_W      = RES_W - LO_W,
    localparam int STEP_W    = $clog2(RES_W + 1),
    localparam int WAIT_W    = $clog2(WAIT_TICKS) + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             go_wr_i,
    input  logic             go_wdata_i,
    input  logic             flag_clr_i,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic             hold_o,
    output logic [RES_W-1:0] trial_o,
    output logic [HI_W-1:0]  res_hi_o,
    output logic [LO_W-1:0]  res_lo_o,
    output logic             irq_flag_o
);
    typedef struct packed {
        sar_state_e        st;
        logic [STEP_W-1:0] step;
        logic [WAIT_W-1:0] wcnt;
        logic [RES_W-1:0]  trial;
        logic              go;
        logic              hold;
        logic              flag;
        logic              en;
    } ctrl_t;

    localparam logic [RES_W-1:0] MSB_CODE = RES_W'(1) << (RES_W - 1);

    ctrl_t             ctl_d, ctl_q;
    logic              load_d;
    logic [STEP_W-1:0] bit_idx;
    logic [RES_W-1:0]  step_trial;

    assign bit_idx = STEP_W'(RES_W - 1) - ctl_q.step;

    sar_bit_step #(.RES_W(RES_W), .IDX_W(STEP_W)) u_step (
        .trial_i (ctl_q.trial),
        .idx_i   (bit_idx),
        .cmp_i   (cmp_i),
        .trial_o (step_trial)
    );

    always_comb begin
        ctl_d    = ctl_q;
        load_d   = 1'b0;
        ctl_d.en = en_i;

        // software clear first so a completion in the same clock wins
        if (flag_clr_i) ctl_d.flag = 1'b0;

        if (tick_i) begin
            unique case (ctl_q.st)
                ST_IDLE: begin
                    if (ctl_q.go) begin
                        ctl_d.st    = ST_CONV;
                        ctl_d.step  = '0;
                        ctl_d.trial = MSB_CODE;
                        ctl_d.hold  = 1'b1;
                    end
                end
                ST_CONV: begin
                    if (!ctl_q.go) begin
                        ctl_d.st    = ST_ABORT;
                        ctl_d.wcnt  = '0;
                        ctl_d.trial = '0;
                    end else if (ctl_q.step == STEP_W'(RES_W)) begin
                        load_d      = 1'b1;
                        ctl_d.st    = ST_IDLE;
                        ctl_d.go    = 1'b0;
                        ctl_d.flag  = 1'b1;
                        ctl_d.hold  = 1'b0;
                        ctl_d.trial = '0;
                    end else begin
                        ctl_d.trial = step_trial;
                        ctl_d.step  = ctl_q.step + 1'b1;
                    end
                end
                ST_ABORT: begin
                    if (ctl_q.wcnt == WAIT_W'(WAIT_TICKS - 1)) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.hold = 1'b0;
                    end else begin
                        ctl_d.wcnt = ctl_q.wcnt + 1'b1;
                    end
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end

        if (go_wr_i) begin
            if (!go_wdata_i) begin
                ctl_d.go = 1'b0;
            end else if (en_i && ctl_q.en && ctl_q.st != ST_CONV) begin
                ctl_d.go = 1'b1;
            end
        end

        if (!en_i) begin
            ctl_d.st    = ST_IDLE;
            ctl_d.go    = 1'b0;
            ctl_d.hold  = 1'b0;
            ctl_d.trial = '0;
            ctl_d.step  = '0;
            ctl_d.wcnt  = '0;
            load_d      = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{st: ST_IDLE, step: '0, wcnt: '0, trial: '0,
                       go: 1'b0, hold: 1'b0, flag: 1'b0, en: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sar_result_reg #(.RES_W(RES_W), .LO_W(LO_W)) u_res (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load_d),
        .data_i (ctl_q.trial),
        .hi_o   (res_hi_o),
        .lo_o   (res_lo_o)
    );

    assign busy_o     = ctl_q.go;
    assign hold_o     = ctl_q.hold;
    assign trial_o    = ctl_q.trial;
    assign irq_flag_o = ctl_q.flag;
endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk #(
    parameter int RES_W = 10,
    parameter int LO_W  = 8,
    localparam int HI_W = RES_W - LO_W
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic             en_i,
    input logic             go_wr_i,
    input logic             go_wdata_i,
    input logic             flag_clr_i,
    input logic             busy_o,
    input logic             hold_o,
    input logic [RES_W-1:0] trial_o,
    input logic [HI_W-1:0]  res_hi_o,
    input logic [LO_W-1:0]  res_lo_o,
    input logic             irq_flag_o
);
    assert_done_together_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_flag_o) |-> (!hold_o && !busy_o));

    assert_hold_opens_on_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hold_o) |-> (busy_o && $past(tick_i)));

    assert_result_only_on_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable({res_hi_o, res_lo_o}) |-> ($past(tick_i) && !hold_o && !busy_o));

    assert_trial_moves_on_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(trial_o) |-> ($past(tick_i) || !$past(en_i)));

    assert_start_needs_prior_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(go_wr_i && go_wdata_i) && !$past(en_i, 2) && !$past(busy_o)) |-> !busy_o);

    assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(irq_flag_o) && !$past(flag_clr_i)) |-> irq_flag_o);
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.RES_W(RES_W), .LO_W(LO_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .en_i       (en_i),
    .go_wr_i    (go_wr_i),
    .go_wdata_i (go_wdata_i),
    .flag_clr_i (flag_clr_i),
    .busy_o     (busy_o),
    .hold_o     (hold_o),
    .trial_o    (trial_o),
    .res_hi_o   (res_hi_o),
    .res_lo_o   (res_lo_o),
    .irq_flag_o (irq_flag_o)
);

// File: tb/sar_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_seq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, en = 1'b0, go_wr = 1'b0, go_wdata = 1'b0, flag_clr = 1'b0;
    logic       cmp;
    logic       busy, hold, irq;
    logic [9:0] trial;
    logic [1:0] res_hi;
    logic [7:0] res_lo;
    logic [9:0] vin = '0;

    int checks = 0;
    int fails  = 0;
    logic [9:0] exp_q[$];
    logic prev_irq = 1'b0;

    always #2.5 clk = ~clk;

    // ideal comparator: 1 when the input is at or above the trial code
    assign cmp = (vin >= trial);

    sar_seq_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .en_i(en),
        .go_wr_i(go_wr), .go_wdata_i(go_wdata), .flag_clr_i(flag_clr),
        .cmp_i(cmp), .busy_o(busy), .hold_o(hold), .trial_o(trial),
        .res_hi_o(res_hi), .res_lo_o(res_lo), .irq_flag_o(irq)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: every new completion pops one expected code
    always @(negedge clk) begin
        if (rst_n && irq && !prev_irq) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected completion", {22'd0, res_hi, res_lo}, 32'd0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                chk({res_hi, res_lo} == e, "R2 result pair", {22'd0, res_hi, res_lo}, {22'd0, e});
            end
        end
        prev_irq <= irq;
    end

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic wr_go(input logic v);
        @(negedge clk) begin go_wr = 1'b1; go_wdata = v; end
        @(negedge clk) go_wr = 1'b0;
    endtask

    task automatic clr_flag();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    // 10 ticks after the start tick, then the completing 11th
    task automatic finish_conv();
        tick_n(10);
        chk(busy == 1'b1, "R3 busy after 10th tick", busy, 1);
        chk(hold == 1'b1, "R4 hold open before completion", hold, 1);
        do_tick();
        chk(busy == 1'b0, "R3 busy cleared on 11th tick", busy, 0);
        chk(hold == 1'b0, "R4 hold closed on completion", hold, 0);
        chk(irq == 1'b1, "R4 flag set on completion", irq, 1);
    endtask

    task automatic convert(input logic [9:0] v);
        clr_flag();
        vin = v;
        exp_q.push_back(v);
        wr_go(1'b1);
        chk(busy == 1'b1, "R3 start accepted", busy, 1);
        do_tick();
        chk(trial == 10'h200, "R1 first trial code", trial, 10'h200);
        chk(hold == 1'b1, "R4 hold opens at start", hold, 1);
        finish_conv();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset values
        chk({busy, hold, irq} == 3'b000, "R12 control outputs", {busy, hold, irq}, 0);
        chk({res_hi, res_lo} == 10'd0, "R12 result", {res_hi, res_lo}, 0);
        chk(trial == 10'd0, "R12 trial", trial, 0);

        en = 1'b1;
        repeat (2) @(negedge clk);

        // R2 several codes
        convert(10'h000);
        convert(10'h3FF);
        convert(10'h200);
        convert(10'h1FF);
        convert(10'h155);

        // R11 no tick, no progress; R1 step order
        clr_flag();
        vin = 10'h000;
        exp_q.push_back(10'h000);
        wr_go(1'b1);
        for (int i = 0; i < 20; i++) @(negedge clk);
        chk(hold == 1'b0, "R11 hold without tick", hold, 0);
        chk(trial == 10'd0, "R11 trial without tick", trial, 0);
        do_tick();
        chk(trial == 10'h200, "R1 start code", trial, 10'h200);
        do_tick();
        chk(trial == 10'h100, "R1 bit9 dropped, bit8 tried", trial, 10'h100);
        tick_n(9);
        chk(busy == 1'b1, "R3 busy after 10th tick", busy, 1);
        do_tick();
        chk(busy == 1'b0 && irq == 1'b1, "R3 completion on 11th tick", {busy, irq}, 2'b01);

        // R8 second start while running
        clr_flag();
        vin = 10'h1C3;
        exp_q.push_back(10'h1C3);
        wr_go(1'b1);
        do_tick();
        tick_n(4);
        wr_go(1'b1);
        tick_n(6);
        chk(busy == 1'b1, "R8 timing unchanged, still busy", busy, 1);
        do_tick();
        chk(busy == 1'b0, "R8 completes on original schedule", busy, 0);

        // R5 and R6 abort then restart
        clr_flag();
        vin = 10'h3FF;
        wr_go(1'b1);
        do_tick();
        tick_n(4);
        wr_go(1'b0);
        chk(busy == 1'b0, "R5 busy clears on write", busy, 0);
        do_tick();
        chk(hold == 1'b1, "R6 hold open at abort tick", hold, 1);
        chk({res_hi, res_lo} == 10'h1C3, "R5 result kept", {res_hi, res_lo}, 10'h1C3);
        chk(irq == 1'b0, "R5 no flag on abort", irq, 0);
        do_tick();
        chk(hold == 1'b1, "R6 hold open during wait", hold, 1);
        vin = 10'h0F0;
        exp_q.push_back(10'h0F0);
        wr_go(1'b1);
        chk(hold == 1'b1, "R6 pending start waits", hold, 1);
        do_tick();
        chk(hold == 1'b0, "R6 hold closes after second wait tick", hold, 0);
        do_tick();
        chk(hold == 1'b1 && trial == 10'h200, "R6 restart after wait", {hold, trial}, {1'b1, 10'h200});
        finish_conv();

        // R9 clear and completion together
        vin = 10'h2AA;
        exp_q.push_back(10'h2AA);
        clr_flag();
        wr_go(1'b1);
        do_tick();
        tick_n(10);
        @(negedge clk) begin tick = 1'b1; flag_clr = 1'b1; end
        @(negedge clk) begin tick = 1'b0; flag_clr = 1'b0; end
        chk(irq == 1'b1, "R9 set wins over clear", irq, 1);
        repeat (3) @(negedge clk);
        chk(irq == 1'b1, "R9 flag sticky", irq, 1);
        clr_flag();
        chk(irq == 1'b0, "R9 flag cleared", irq, 0);

        // R10 disable mid-conversion
        vin = 10'h0AA;
        wr_go(1'b1);
        do_tick();
        tick_n(5);
        @(negedge clk) en = 1'b0;
        @(negedge clk);
        chk({busy, hold} == 2'b00, "R10 idle after disable", {busy, hold}, 0);
        chk(trial == 10'd0, "R10 trial cleared", trial, 0);
        chk({res_hi, res_lo} == 10'h2AA, "R10 result kept", {res_hi, res_lo}, 10'h2AA);
        chk(irq == 1'b0, "R10 flag untouched", irq, 0);

        // R7 enable and start in the same clock
        repeat (2) @(negedge clk);
        @(negedge clk) begin en = 1'b1; go_wr = 1'b1; go_wdata = 1'b1; end
        @(negedge clk) go_wr = 1'b0;
        chk(busy == 1'b0, "R7 start with enable ignored", busy, 0);
        tick_n(3);
        chk(hold == 1'b0, "R7 no conversion", hold, 0);
        convert(10'h2AA);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule